// File: doc/BRIEF.md
# Sample Pipeline Cell Manager

This block keeps the addresses of a circular analog sample store in a front-end readout chip. The charge cells and the converter sit outside. The block only decides which cell takes the next sample and which cells must be held for conversion. On each sample tick the current sample goes into the cell named by the write address. The write address then moves to the next cell in ring order that is not held.

A level-1 accept picks the cell that was written a fixed number of ticks earlier, set by the latency parameter. That cell is locked against overwriting and is appended to a queue of cells waiting for conversion. The queue head is the oldest locked cell. A done pulse from the converter releases the head cell, which returns to the ring. The queue holds at most one cell per second-level buffer. An accept that finds the queue full is dropped and sets a sticky error flag.

The latency must be smaller than the cell count minus the queue depth. This keeps a triggered cell from being rewritten before its accept arrives.

Top module: `pcm_cell_mgr`

## Requirements
- R1: After reset, wr_addr is 0, lock_count is 0, lock_valid is 0 and ovf_err is 0. No cell is locked.
- R2: In a cycle with sample_tick high, wr_addr names the cell being written. On the following edge it moves forward in ascending ring order, wrapping from NUM_CELLS-1 to 0. Without sample_tick it holds.
- R3: wr_addr never names a locked cell. When advancing, it passes over every locked cell.
- R4: An l1a accepted in a cycle locks the cell written at the LATENCY-th most recent sample tick before that cycle. The most recent tick counts as the first. lock_count rises by one on the next edge, and lock_count never exceeds MAX_LOCKS.
- R5: Locked cells leave in the order they were locked. lock_head shows the oldest locked cell whenever lock_valid is high. A dig_done pulse removes it on the next edge.
- R6: A cell released by dig_done is writable again: wr_addr stops on it the next time the pointer reaches it.
- R7: An l1a that would lock a new cell while MAX_LOCKS cells are held, with no dig_done in the same cycle, is dropped. It sets ovf_err, which stays high until reset.
- R8: An l1a that arrives before LATENCY sample ticks have occurred since reset is ignored.
- R9: An l1a whose target cell is already locked changes nothing and does not set ovf_err.
- R10: dig_done with no locked cell is ignored.
- R11: When the queue is full and dig_done and an l1a for a new cell arrive in the same cycle, the head is released and the new cell is appended. lock_count stays at MAX_LOCKS and ovf_err is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_tick | input | 1 | Clock enable: a sample is stored this cycle |
| l1a | input | 1 | Level-1 accept pulse |
| dig_done | input | 1 | Conversion of the queue head has finished |
| wr_addr | output | $clog2(NUM_CELLS) | Cell written on the current tick |
| lock_head | output | $clog2(NUM_CELLS) | Oldest locked cell, next to convert |
| lock_valid | output | 1 | At least one cell is locked |
| lock_count | output | $clog2(MAX_LOCKS+1) | Number of locked cells |
| ovf_err | output | 1 | Sticky: an accept was dropped on a full queue |

## Verification
A corrupted lock mask shows on wr_addr within a single ring revolution. The pointer either stops on a cell it should pass over or skips a free one. A queue pointer or count error shows at lock_head or lock_count on the first release after it. A wrong tick history locks the wrong cell, and this appears as soon as that cell reaches the queue head. It also appears when the pointer next sweeps past that cell. The bench compares every output with an arithmetic reference model on every cycle over long mixed stimulus, so any of these faults is reported within a few ticks of becoming visible.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  // queue operation selected each cycle
  typedef enum logic [1:0] {
    Q_IDLE = 2'b00,
    Q_POP  = 2'b01,
    Q_PUSH = 2'b10,
    Q_SWAP = 2'b11
  } q_op_e;

endpackage

// File: rtl/pcm_hist.sv
module pcm_hist #(
  parameter int AW  = 6,
  parameter int LAT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] wr_addr,
  output logic [AW-1:0] tgt_addr,
  output logic          tgt_valid
);

  localparam int FW = $clog2(LAT + 1);

  logic [AW-1:0] hist_q   [LAT];
  logic [AW-1:0] hist_d   [LAT];
  logic [AW-1:0] shift_in [LAT];
  logic [FW-1:0] fill_q, fill_d;

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign shift_in[g] = wr_addr;
    end else begin : g_tail
      assign shift_in[g] = hist_q[g-1];
    end
  end

  always_comb begin
    hist_d = tick ? shift_in : hist_q;
    fill_d = fill_q;
    if (tick && (fill_q != FW'(LAT))) begin
      fill_d = fill_q + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) hist_q[i] <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

  assign tgt_addr  = hist_q[LAT-1];
  assign tgt_valid = (fill_q == FW'(LAT));

  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(fill_q)); // R8

  AST_VALID_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_valid) |-> $past(tick)); // R8

endmodule

// File: rtl/pcm_lock_fifo.sv
module pcm_lock_fifo
  import pcm_pkg::*;
#(
  parameter int NCELL = 46,
  parameter int AW    = 6,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l1a,
  input  logic             done,
  input  logic [AW-1:0]    tgt_addr,
  input  logic             tgt_valid,
  output logic [NCELL-1:0] mask_q,
  output logic [NCELL-1:0] mask_d,
  output logic [AW-1:0]    head,
  output logic [CW-1:0]    count,
  output logic             ovf
);

  localparam int QW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] slot_q [DEPTH];
  logic [AW-1:0] slot_d [DEPTH];
  logic [QW-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          ovf_q, ovf_d;
  logic          pop, cand, push, full;
  q_op_e         op;

  function automatic logic [QW-1:0] qinc(input logic [QW-1:0] p);
    return (p == QW'(DEPTH - 1)) ? '0 : p + QW'(1);
  endfunction

  always_comb begin
    full = (count_q == CW'(DEPTH));
    pop  = done && (count_q != '0);
    cand = l1a && tgt_valid && !mask_q[tgt_addr];
    push = cand && (!full || pop);
    op   = q_op_e'({push, pop});
  end

  always_comb begin
    slot_d  = slot_q;
    rptr_d  = rptr_q;
    wptr_d  = wptr_q;
    count_d = count_q;
    mask_d  = mask_q;
    ovf_d   = ovf_q | (cand && full && !pop);
    if (op == Q_POP || op == Q_SWAP) begin
      mask_d[slot_q[rptr_q]] = 1'b0;
      rptr_d = qinc(rptr_q);
    end
    if (op == Q_PUSH || op == Q_SWAP) begin
      mask_d[tgt_addr] = 1'b1;
      slot_d[wptr_q]   = tgt_addr;
      wptr_d = qinc(wptr_q);
    end
    case (op)
      Q_PUSH:  count_d = count_q + CW'(1);
      Q_POP:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      rptr_q  <= '0;
      wptr_q  <= '0;
      count_q <= '0;
      mask_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      rptr_q  <= rptr_d;
      wptr_q  <= wptr_d;
      count_q <= count_d;
      mask_q  <= mask_d;
      ovf_q   <= ovf_d;
    end
  end

  assign head  = slot_q[rptr_q];
  assign count = count_q;
  assign ovf   = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH)); // R4

  AST_MASK_MATCHES_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_q) == int'(count_q)); // R5

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !l1a && count_q == '0) |=> (count_q == '0)); // R10

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(DEPTH) && !done) |=> (count_q == CW'(DEPTH))); // R7

endmodule

// File: rtl/pcm_wr_ptr.sv
module pcm_wr_ptr #(
  parameter int NCELL = 46,
  parameter int AW    = 6,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NCELL-1:0] mask_d,
  output logic [AW-1:0]    wr_addr
);

  logic [AW-1:0] wr_q, wr_d, skip_to;
  logic          found;

  // at most DEPTH cells are locked, so DEPTH+1 candidates always hold a free one
  always_comb begin
    int c;
    found   = 1'b0;
    skip_to = wr_q;
    for (int k = 1; k <= DEPTH + 1; k++) begin
      c = int'(wr_q) + k;
      if (c >= NCELL) c = c - NCELL;
      if (!found && !mask_d[c]) begin
        skip_to = AW'(c);
        found   = 1'b1;
      end
    end
    wr_d = tick ? skip_to : wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else begin
      wr_q <= wr_d;
    end
  end

  assign wr_addr = wr_q;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wr_q)); // R2

  AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (wr_q != $past(wr_q))); // R2

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_q) < NCELL); // R2

endmodule

// File: rtl/pcm_cell_mgr.sv
module pcm_cell_mgr #(
  parameter int NUM_CELLS = 46,
  parameter int LATENCY   = 12,
  parameter int MAX_LOCKS = 4,
  localparam int AW = $clog2(NUM_CELLS),
  localparam int CW = $clog2(MAX_LOCKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic          l1a,
  input  logic          dig_done,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] lock_head,
  output logic          lock_valid,
  output logic [CW-1:0] lock_count,
  output logic          ovf_err
);

  logic                 rst_meta, rst_sync_n;
  logic [NUM_CELLS-1:0] mask_q, mask_d;
  logic [AW-1:0]        tgt_addr;
  logic                 tgt_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pcm_hist #(.AW(AW), .LAT(LATENCY)) u_hist (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (sample_tick),
    .wr_addr   (wr_addr),
    .tgt_addr  (tgt_addr),
    .tgt_valid (tgt_valid)
  );

  pcm_lock_fifo #(.NCELL(NUM_CELLS), .AW(AW), .DEPTH(MAX_LOCKS), .CW(CW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .l1a       (l1a),
    .done      (dig_done),
    .tgt_addr  (tgt_addr),
    .tgt_valid (tgt_valid),
    .mask_q    (mask_q),
    .mask_d    (mask_d),
    .head      (lock_head),
    .count     (lock_count),
    .ovf       (ovf_err)
  );

  pcm_wr_ptr #(.NCELL(NUM_CELLS), .AW(AW), .DEPTH(MAX_LOCKS)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (sample_tick),
    .mask_d  (mask_d),
    .wr_addr (wr_addr)
  );

  assign lock_valid = (lock_count != '0);

  AST_WR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mask_q[wr_addr]); // R3

  AST_HEAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lock_valid |-> mask_q[lock_head]); // R5

endmodule

// File: tb/pcm_cell_mgr_tb.sv
module pcm_cell_mgr_tb;

  localparam int NC = 10;
  localparam int LT = 3;
  localparam int ML = 4;
  localparam int AW = $clog2(NC);
  localparam int CW = $clog2(ML + 1);

  logic          clk, rst_n, sample_tick, l1a, dig_done;
  logic [AW-1:0] wr_addr, lock_head;
  logic          lock_valid, ovf_err;
  logic [CW-1:0] lock_count;

  int n_run, n_fail;
  int m_wr, m_cnt, m_ovf, m_fill;
  int m_q [ML];
  int m_hist [LT];
  bit m_mask [NC];
  logic [15:0] lfsr;

  pcm_cell_mgr #(.NUM_CELLS(NC), .LATENCY(LT), .MAX_LOCKS(ML)) u_dut (
    .clk (clk), .rst_n (rst_n), .sample_tick (sample_tick), .l1a (l1a),
    .dig_done (dig_done), .wr_addr (wr_addr), .lock_head (lock_head),
    .lock_valid (lock_valid), .lock_count (lock_count), .ovf_err (ovf_err)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all R) actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wr = 0; m_cnt = 0; m_ovf = 0; m_fill = 0;
    for (int i = 0; i < NC; i++) m_mask[i] = 1'b0;
    for (int i = 0; i < LT; i++) m_hist[i] = 0;
    for (int i = 0; i < ML; i++) m_q[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sample_tick = 1'b0; l1a = 1'b0; dig_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    chk("R1 wr_addr", int'(wr_addr), 0);
    chk("R1 lock_count", int'(lock_count), 0);
    chk("R1 lock_valid", int'(lock_valid), 0);
    chk("R1 ovf_err", int'(ovf_err), 0);
  endtask

  // reference model of one clock edge, written from the requirements
  task automatic model_step(input bit t, input bit a, input bit d);
    bit tv, pop, cand, push;
    int tg;
    tv   = (m_fill >= LT);
    tg   = m_hist[LT-1];
    pop  = d && (m_cnt > 0);
    cand = a && tv && !m_mask[tg];
    push = cand && ((m_cnt < ML) || pop);
    if (cand && (m_cnt == ML) && !pop) m_ovf = 1;
    if (pop) begin
      m_mask[m_q[0]] = 1'b0;
      for (int i = 0; i < ML - 1; i++) m_q[i] = m_q[i+1];
      m_cnt--;
    end
    if (push) begin
      m_mask[tg] = 1'b1;
      m_q[m_cnt] = tg;
      m_cnt++;
    end
    if (t) begin
      for (int i = LT - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = m_wr;
      if (m_fill < LT) m_fill++;
      for (int k = 1; k <= NC; k++) begin
        if (!m_mask[(m_wr + k) % NC]) begin
          m_wr = (m_wr + k) % NC;
          break;
        end
      end
    end
  endtask

  task automatic cmp_model();
    chk("R3 wr_addr vs model", int'(wr_addr), m_wr);
    chk("R4 lock_count vs model", int'(lock_count), m_cnt);
    chk("R5 lock_valid vs model", int'(lock_valid), int'(m_cnt > 0));
    if (m_cnt > 0) chk("R5 lock_head vs model", int'(lock_head), m_q[0]);
    chk("R7 ovf_err vs model", int'(ovf_err), m_ovf);
  endtask

  task automatic step(input bit t, input bit a, input bit d);
    @(negedge clk);
    sample_tick = t; l1a = a; dig_done = d;
    model_step(t, a, d);
    @(posedge clk);
    #1;
    cmp_model();
  endtask

  initial begin
    n_run = 0; n_fail = 0; lfsr = 16'hACE1;
    rst_n = 1'b0; sample_tick = 1'b0; l1a = 1'b0; dig_done = 1'b0;

    // scenario A: early trigger, lock, duplicate, skip, release
    do_reset();
    step(1, 0, 0); step(1, 0, 0);
    step(0, 1, 0);
    chk("R8 early l1a ignored", int'(lock_count), 0);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    chk("R2 five ticks", int'(wr_addr), 5);
    step(0, 0, 0);
    chk("R2 hold without tick", int'(wr_addr), 5);
    step(0, 1, 0);
    chk("R4 lock count", int'(lock_count), 1);
    chk("R4 locked cell is 3rd most recent", int'(lock_head), 2);
    step(0, 1, 0);
    chk("R9 duplicate l1a count", int'(lock_count), 1);
    chk("R9 duplicate l1a no ovf", int'(ovf_err), 0);
    for (int i = 0; i < 7; i++) step(1, 0, 0);
    chk("R3 skip locked cell 2", int'(wr_addr), 3);
    step(0, 0, 1);
    chk("R5 release empties queue", int'(lock_count), 0);
    for (int i = 0; i < 9; i++) step(1, 0, 0);
    chk("R6 released cell reused", int'(wr_addr), 2);

    // scenario B: fill queue, overflow, swap at full, drain, empty done
    do_reset();
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 0);
      step(1, 0, 0);
    end
    chk("R4 queue full", int'(lock_count), 4);
    chk("R5 head oldest", int'(lock_head), 0);
    step(0, 1, 0);
    chk("R7 dropped on full", int'(lock_count), 4);
    chk("R7 ovf set", int'(ovf_err), 1);
    step(0, 1, 1);
    chk("R11 swap keeps count", int'(lock_count), 4);
    chk("R11 swap advances head", int'(lock_head), 1);
    for (int i = 0; i < 4; i++) begin
      chk("R5 fifo order", int'(lock_head), i + 1);
      step(0, 0, 1);
    end
    chk("R5 drained", int'(lock_count), 0);
    step(0, 0, 1);
    chk("R10 done on empty", int'(lock_count), 0);
    chk("R7 ovf sticky", int'(ovf_err), 1);

    // scenario C: sweep of stimulus densities against the reference model
    for (int p = 0; p < 4; p++) begin
      int tt, ta, td;
      do_reset();
      case (p)
        0: begin tt = 6; ta = 3; td = 1; end
        1: begin tt = 4; ta = 2; td = 3; end
        2: begin tt = 1; ta = 2; td = 2; end
        default: begin tt = 7; ta = 4; td = 6; end
      endcase
      for (int n = 0; n < 2500; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(int'(lfsr[2:0]) < tt, int'(lfsr[7:4]) < ta, int'(lfsr[11:9]) < td);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule